// File: doc/BRIEF.md
# Sector Write-Protection Gate

This block judges every program or erase request aimed at a flash array and decides whether the addressed sector may be changed. It turns the word address into a sector number using a non-uniform map. The address space is split into banks of equal-sized large sectors. The last large slot of the top bank is divided into a set of small boot sectors. It then checks that sector against every lock source:

- a global lock pin (active low);
- a supply-fault flag;
- a boot write-protect pin (active low) that guards the two highest-numbered sectors;
- a per-sector persistent protection bit array.

In password mode the persistent protection bits cannot be bypassed until a caller presents a 64-bit password that matches the stored one.

The verdict is registered. One clock cycle after a request is accepted, the block returns a valid strobe, an allow bit, the decoded sector number and an echo of the request kind. The nonvolatile storage for the protection bits and the password lives outside this block and reaches it as plain inputs. A controller uses the allow bit to start or refuse an embedded program or erase. A refused erase is refused as a whole.

Top module: `sector_guard`

## Requirements
- R1: With S = BANK_W+SLOT_W slot bits, the slot number is address bits [AW-1:BIG_W]. An address whose slot number is below 2^S-1 maps to sector number equal to that slot number.
- R2: An address in the last slot (all slot bits one) maps to sector (2^S-1) + address bits [BIG_W-1:SMALL_W]. This gives 2^(BIG_W-SMALL_W) small sectors, and NSECT = 2^S-1+2^(BIG_W-SMALL_W) sectors in all.
- R3: A request with req_valid high at a rising edge produces rsp_valid high for exactly one cycle after that edge, carrying its sector and kind. Without a request, rsp_valid and rsp_allow are 0. After reset both are 0.
- R4: While acc_n is 0, every request is denied.
- R5: While low_vcc is 1, every request is denied.
- R6: While wp_n is 0, requests to sectors NSECT-2 and NSECT-1 are denied. The pin has no effect on any other sector.
- R7: With pw_mode 0, a request to sector i is denied when ppb_bits[i] is 1. Otherwise, with no other lock, it is allowed.
- R8: With pw_mode 1, sectors whose ppb_bits bit is 1 stay denied until a pw_valid cycle carries pw_data equal to pw_stored. After that they are allowed, provided no other lock source applies.
- R9: A pw_valid cycle whose pw_data differs from pw_stored leaves a locked password state locked.
- R10: Once unlocked, the password state stays unlocked until reset. Reset returns it to locked.
- R11: Program (req_erase 0) and erase (req_erase 1) requests get the same verdict for the same sector and lock state. rsp_erase echoes req_erase.
- R12: An accepted password takes effect from the next cycle. A request in the same cycle as the password is judged with the old locked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_erase | input | 1 | 1 = erase, 0 = program |
| req_addr | input | AW | Word address of the target |
| wp_n | input | 1 | Boot write-protect pin, active low |
| acc_n | input | 1 | Global lock pin, active low |
| low_vcc | input | 1 | Supply below write threshold |
| ppb_bits | input | NSECT | Persistent protection bit per sector |
| pw_mode | input | 1 | Password mode selected |
| pw_valid | input | 1 | Password presented this cycle |
| pw_data | input | PW_W | Presented password |
| pw_stored | input | PW_W | Stored password |
| rsp_valid | output | 1 | Verdict valid |
| rsp_allow | output | 1 | 1 = modification permitted |
| rsp_sector | output | IW | Decoded sector number |
| rsp_erase | output | 1 | Echo of the request kind |

## Verification
The properties assume that every sideband input is sampled at the rising edge together with req_valid or pw_valid. They also assume that pw_stored is steady whenever a password is compared. The bench changes all inputs only on falling edges and keeps the stored password constant for the whole run. It sweeps every address of a small configuration (8 address bits, 19 sectors) under each lock source in turn. Expected sector numbers and verdicts are computed arithmetically from the requirement formulas.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef struct packed {
    logic pin_all;
    logic supply;
    logic boot;
    logic persist;
  } lock_src_t;
endpackage

// File: rtl/sg_sector_map.sv
module sg_sector_map #(
  parameter int BANK_W  = 4,
  parameter int SLOT_W  = 4,
  parameter int BIG_W   = 16,
  parameter int SMALL_W = 14,
  localparam int SW     = BANK_W + SLOT_W,
  localparam int AW     = SW + BIG_W,
  localparam int NBIG   = (1 << SW) - 1,
  localparam int NSMALL = 1 << (BIG_W - SMALL_W),
  localparam int NSECT  = NBIG + NSMALL,
  localparam int IW     = $clog2(NSECT)
) (
  input  logic [AW-1:0] addr,
  output logic [IW-1:0] sector,
  output logic          in_small,
  output logic          boot_top
);
  function automatic logic [IW-1:0] calc_sector(input logic [AW-1:0] a);
    logic [SW-1:0] slot;
    slot = a[AW-1:BIG_W];
    if (slot == {SW{1'b1}})
      return IW'(NBIG) + IW'(a[BIG_W-1:SMALL_W]);
    else
      return IW'(slot);
  endfunction

  logic unused_low;
  assign unused_low = ^addr[SMALL_W-1:0];

  assign sector   = calc_sector(addr);
  assign in_small = (addr[AW-1:BIG_W] == {SW{1'b1}});
  assign boot_top = (sector >= IW'(NSECT - 2));
endmodule

// File: rtl/sg_pw_latch.sv
module sg_pw_latch #(
  parameter int PW_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pw_valid,
  input  logic [PW_W-1:0] pw_data,
  input  logic [PW_W-1:0] pw_stored,
  output logic            pw_hit,
  output logic            unlocked
);
  assign pw_hit = pw_valid && (pw_data == pw_stored);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (pw_hit) unlocked <= 1'b1;
  end

  p_hit_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pw_hit |=> unlocked);
  p_wrong_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_valid && (pw_data != pw_stored) && !unlocked) |=> !unlocked);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unlocked |=> unlocked);
endmodule

// File: rtl/sg_lock_eval.sv
module sg_lock_eval
  import sg_pkg::*;
#(
  parameter int NSECT = 259,
  localparam int IW   = $clog2(NSECT)
) (
  input  logic [IW-1:0]    sector,
  input  logic             boot_top,
  input  logic [NSECT-1:0] ppb_bits,
  input  logic             wp_n,
  input  logic             acc_n,
  input  logic             low_vcc,
  input  logic             pw_mode,
  input  logic             unlocked,
  output logic             ppb_hit,
  output lock_src_t        src,
  output logic             allow
);
  assign ppb_hit = ppb_bits[sector];

  always_comb begin
    src.pin_all = !acc_n;
    src.supply  = low_vcc;
    src.boot    = !wp_n && boot_top;
    src.persist = ppb_hit && !(pw_mode && unlocked);
  end

  assign allow = (src == '0);
endmodule

// File: rtl/sector_guard.sv
module sector_guard
  import sg_pkg::*;
#(
  parameter int BANK_W  = 4,
  parameter int SLOT_W  = 4,
  parameter int BIG_W   = 16,
  parameter int SMALL_W = 14,
  parameter int PW_W    = 64,
  localparam int SW     = BANK_W + SLOT_W,
  localparam int AW     = SW + BIG_W,
  localparam int NSECT  = (1 << SW) - 1 + (1 << (BIG_W - SMALL_W)),
  localparam int IW     = $clog2(NSECT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_erase,
  input  logic [AW-1:0]    req_addr,
  input  logic             wp_n,
  input  logic             acc_n,
  input  logic             low_vcc,
  input  logic [NSECT-1:0] ppb_bits,
  input  logic             pw_mode,
  input  logic             pw_valid,
  input  logic [PW_W-1:0]  pw_data,
  input  logic [PW_W-1:0]  pw_stored,
  output logic             rsp_valid,
  output logic             rsp_allow,
  output logic [IW-1:0]    rsp_sector,
  output logic             rsp_erase
);
  logic [IW-1:0] map_sector;
  logic          map_small;
  logic          map_boot;
  logic          pw_hit;
  logic          pw_unlocked;
  logic          ppb_hit;
  lock_src_t     lock_src;
  logic          verdict;

  sg_sector_map #(
    .BANK_W(BANK_W), .SLOT_W(SLOT_W), .BIG_W(BIG_W), .SMALL_W(SMALL_W)
  ) u_map (
    .addr(req_addr), .sector(map_sector), .in_small(map_small), .boot_top(map_boot)
  );

  sg_pw_latch #(.PW_W(PW_W)) u_pw (
    .clk(clk), .rst_n(rst_n), .pw_valid(pw_valid), .pw_data(pw_data),
    .pw_stored(pw_stored), .pw_hit(pw_hit), .unlocked(pw_unlocked)
  );

  sg_lock_eval #(.NSECT(NSECT)) u_eval (
    .sector(map_sector), .boot_top(map_boot), .ppb_bits(ppb_bits),
    .wp_n(wp_n), .acc_n(acc_n), .low_vcc(low_vcc), .pw_mode(pw_mode),
    .unlocked(pw_unlocked), .ppb_hit(ppb_hit), .src(lock_src), .allow(verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_allow  <= 1'b0;
      rsp_sector <= '0;
      rsp_erase  <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_allow  <= req_valid && verdict;
      rsp_sector <= map_sector;
      rsp_erase  <= req_erase;
    end
  end

  p_resp_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_allow));
  p_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_sector < IW'(NSECT)));
  p_small_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !map_small) |=> (rsp_sector < IW'((1 << SW) - 1)));
  p_acc_deny_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_n) |=> !rsp_allow);
  p_supply_deny_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && low_vcc) |=> !rsp_allow);
  p_boot_deny_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !wp_n && map_boot) |=> !rsp_allow);
  p_ppb_deny_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ppb_hit && !pw_mode) |=> !rsp_allow);
  p_same_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pw_mode && ppb_hit && !pw_unlocked) |=> !rsp_allow);
  p_kind_echo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_erase == $past(req_erase)));
endmodule

// File: tb/sector_guard_bench.sv
module sector_guard_bench;
  localparam int BANK_W = 2, SLOT_W = 2, BIG_W = 4, SMALL_W = 2, PW_W = 64;
  localparam int AW = 8, NSECT = 19, IW = 5;
  localparam logic [PW_W-1:0] KEY = 64'hC0FF_EE12_3456_789A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_erase = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic wp_n = 1'b1, acc_n = 1'b1, low_vcc = 1'b0;
  logic [NSECT-1:0] ppb_bits = '0;
  logic pw_mode = 1'b0, pw_valid = 1'b0;
  logic [PW_W-1:0] pw_data = '0, pw_stored = KEY;
  logic rsp_valid, rsp_allow, rsp_erase;
  logic [IW-1:0] rsp_sector;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  sector_guard #(.BANK_W(BANK_W), .SLOT_W(SLOT_W), .BIG_W(BIG_W),
    .SMALL_W(SMALL_W), .PW_W(PW_W)) u_sector_guard (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
    .req_addr(req_addr), .wp_n(wp_n), .acc_n(acc_n), .low_vcc(low_vcc),
    .ppb_bits(ppb_bits), .pw_mode(pw_mode), .pw_valid(pw_valid),
    .pw_data(pw_data), .pw_stored(pw_stored), .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow), .rsp_sector(rsp_sector), .rsp_erase(rsp_erase));

  function automatic int exp_sector(input int a);
    int slot = a / 16;
    if (slot == 15) return 15 + (a % 16) / 4;
    return slot;
  endfunction

  function automatic bit ppb_pat(input int s);
    return (s % 3) == 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_req(input int a, input bit er, input bit exp_allow, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(a); req_erase = er;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid R3"}, int'(rsp_valid), 1);
    check({tag, " sector R1/R2"}, int'(rsp_sector), exp_sector(a));
    check({tag, " kind R11"}, int'(rsp_erase), int'(er));
    check({tag, " allow"}, int'(rsp_allow), int'(exp_allow));
  endtask

  task automatic send_pw(input logic [PW_W-1:0] v);
    @(negedge clk);
    pw_valid = 1'b1; pw_data = v;
    @(negedge clk);
    pw_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("reset valid R3", int'(rsp_valid), 0);
    check("reset allow R3", int'(rsp_allow), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("idle valid R3", int'(rsp_valid), 0);

    for (int a = 0; a < 256; a++) do_req(a, a[0], 1'b1, "open R1 R2");
    acc_n = 1'b0;
    for (int a = 0; a < 256; a++) do_req(a, 1'b0, 1'b0, "acc R4");
    acc_n = 1'b1; low_vcc = 1'b1;
    for (int a = 0; a < 256; a++) do_req(a, 1'b1, 1'b0, "vcc R5");
    low_vcc = 1'b0; wp_n = 1'b0;
    for (int a = 0; a < 256; a++) do_req(a, 1'b0, exp_sector(a) < NSECT - 2, "wp R6");
    wp_n = 1'b1;
    for (int s = 0; s < NSECT; s++) ppb_bits[s] = ppb_pat(s);
    for (int a = 0; a < 256; a++) begin
      do_req(a, 1'b0, !ppb_pat(exp_sector(a)), "ppb prog R7");
      do_req(a, 1'b1, !ppb_pat(exp_sector(a)), "ppb erase R11");
    end
    pw_mode = 1'b1;
    for (int a = 0; a < 256; a++) do_req(a, 1'b1, !ppb_pat(exp_sector(a)), "pw locked R8");
    send_pw(KEY ^ 64'h1);
    send_pw(64'h0);
    for (int a = 0; a < 256; a++) do_req(a, 1'b0, !ppb_pat(exp_sector(a)), "wrong pw R9");
    @(negedge clk);
    pw_valid = 1'b1; pw_data = KEY; req_valid = 1'b1; req_addr = 8'h00; req_erase = 1'b0;
    @(negedge clk);
    pw_valid = 1'b0; req_valid = 1'b0;
    check("same cycle R12", int'(rsp_allow), 0);
    do_req(0, 1'b0, 1'b1, "next cycle R12");
    for (int a = 0; a < 256; a++) do_req(a, a[1], 1'b1, "unlocked R8");
    send_pw(KEY ^ 64'h8000_0000_0000_0000);
    for (int a = 0; a < 256; a += 3) do_req(a, 1'b1, 1'b1, "sticky R10");
    wp_n = 1'b0;
    for (int a = 0; a < 256; a++) do_req(a, 1'b0, exp_sector(a) < NSECT - 2, "wp over pw R6");
    wp_n = 1'b1;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("in reset valid R3", int'(rsp_valid), 0);
    rst_n = 1'b1;
    for (int a = 0; a < 256; a++) do_req(a, 1'b1, !ppb_pat(exp_sector(a)), "relock R10");
    pw_mode = 1'b0; ppb_bits = '0;
    for (int a = 240; a < 256; a++) do_req(a, 1'b0, 1'b1, "small sectors R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule